// File: doc/BRIEF.md
# Counting Level-Sensitive Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt lines (64 by default) into a single request line to the processor. Each source has an enable flag. A source is pending while its sampled input is high and its flag is set. The block keeps a running count of pending sources and raises the processor request whenever that count is non-zero.

Software reaches the block through a simple synchronous register port inside a 4 KB window. The register number is taken from address bits [11:2]. Sources are switched on or off one at a time by writing a source number. A single write to a separate register switches every source off. Software can read the pending count and the number of the lowest-numbered pending source.

The inputs are registered once before use. Read data appears one cycle after the read strobe.

Top module: `cnt_irq_ctrl`

## Requirements
- R1: After reset every enable flag is clear, the pending count is 0 and `irq_o` is low.
- R2: Register numbers come from `addr_i[11:2]`. Register 0 reads the identifier parameter `ID_CODE`. Registers 3, 4 and 5, and every number above 5, read as zero.
- R3: Register 1 reads the number of sources whose sampled input is high and whose enable flag is set, zero-extended. `irq_o` is high exactly when that number is non-zero.
- R4: Register 2 reads the lowest-numbered pending source, zero-extended. It reads 0xFFFFFFFF when nothing is pending.
- R5: A write of any value to register 3 clears every enable flag and brings the count to zero.
- R6: A write of source number n to register 5 sets flag n. The count rises by one only if the flag was clear and input n is high, so enabling an enabled source changes nothing.
- R7: A write of source number n to register 4 clears flag n. The count falls by one only if source n was pending.
- R8: An enable or disable write whose full 32-bit value is not less than `NUM_SRC` leaves all flags and the count unchanged. This holds even when the value's low bits name a valid source.
- R9: A rising or falling input on an enabled source moves the count up or down by one. Input changes on disabled sources leave the count unchanged.
- R10: When an input change and an enable or disable write touch the count in the same cycle, both effects are applied.
- R11: Writes to registers 0, 1 and 2, and to numbers above 5, have no effect.
- R12: `rdata_o` takes the value of the addressed register on the clock edge where `rd_en_i` is high. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address inside the window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Request to the processor |

## Verification
The hardest situation to reach is an enable or disable write landing in the very cycle that the same source's input toggles. Both effects must then reach the running count exactly once. Directed steps line up the write strobe and the input edge on one clock, for both the enable case and the disable case. The random phase then drives input changes and register writes together on every step. Out-of-range values whose low bits alias a live source are aimed at sources whose inputs are high, so that a wrongly truncated compare would show in the count.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned REG_IDX_W = 10;
  localparam logic [REG_IDX_W-1:0] RG_IDENT   = 10'd0;
  localparam logic [REG_IDX_W-1:0] RG_COUNT   = 10'd1;
  localparam logic [REG_IDX_W-1:0] RG_LOWEST  = 10'd2;
  localparam logic [REG_IDX_W-1:0] RG_OFF_ALL = 10'd3;
  localparam logic [REG_IDX_W-1:0] RG_OFF_ONE = 10'd4;
  localparam logic [REG_IDX_W-1:0] RG_ON_ONE  = 10'd5;
endpackage

// File: rtl/cic_popcount.sv
module cic_popcount #(
  parameter int unsigned W     = 64,
  parameter int unsigned OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [OUT_W-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) begin
      ones_o = ones_o + OUT_W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/cic_prio_enc.sv
module cic_prio_enc #(
  parameter int unsigned W     = 64,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end

  // R4: the chosen source is pending and no lower one is
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_o |-> (req_i[idx_o] && ((req_i & ((W'(1) << idx_o) - W'(1))) == '0)));
  a_r4_none_pending: assert property (@(posedge clk) disable iff (!rst_ni)
    !vld_o |-> (req_i == '0));
endmodule

// File: rtl/cic_src_bank.sv
module cic_src_bank #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               off_all_i,
  input  logic               off_one_i,
  input  logic               on_one_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               idx_ok_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] fall_o
);
  logic [NUM_SRC-1:0] lvl_q, en_q, en_d, pend_d;
  logic               en_ce;

  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    if (off_all_i) begin
      en_d  = '0;
      en_ce = 1'b1;
    end else if (on_one_i && idx_ok_i) begin
      en_d[idx_i] = 1'b1;
      en_ce       = 1'b1;
    end else if (off_one_i && idx_ok_i) begin
      en_d[idx_i] = 1'b0;
      en_ce       = 1'b1;
    end
  end

  assign pend_d = src_i & en_d;
  assign pend_o = lvl_q & en_q;
  assign rise_o = pend_d & ~pend_o;
  assign fall_o = pend_o & ~pend_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      en_q  <= '0;
    end else begin
      lvl_q <= src_i;
      if (en_ce) en_q <= en_d;
    end
  end

  a_r5_all_flags_off: assert property (@(posedge clk) disable iff (!rst_ni)
    off_all_i |=> (en_q == '0));
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_ni)
    (on_one_i && idx_ok_i) |=> en_q[$past(idx_i)]);
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (off_one_i && idx_ok_i) |=> !en_q[$past(idx_i)]);
  a_r8_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    ((on_one_i || off_one_i) && !idx_ok_i && !off_all_i) |=> $stable(en_q));
endmodule

// File: rtl/cic_regif.sv
module cic_regif
  import cic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = $clog2(NUM_SRC + 1),
  parameter int unsigned IDX_W   = $clog2(NUM_SRC),
  parameter logic [DATA_W-1:0] ID_CODE = 32'hC1C0_0040
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  low_idx_i,
  input  logic              low_vld_i,
  output logic              off_all_o,
  output logic              off_one_o,
  output logic              on_one_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_ok_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [REG_IDX_W-1:0] rsel;
  logic [DATA_W-1:0]    rdata_d;
  logic                 unused_addr;

  assign rsel        = addr_i[REG_IDX_W+1:2];
  assign unused_addr = ^addr_i[1:0];

  assign off_all_o = wr_en_i && (rsel == RG_OFF_ALL);
  assign off_one_o = wr_en_i && (rsel == RG_OFF_ONE);
  assign on_one_o  = wr_en_i && (rsel == RG_ON_ONE);
  assign idx_o     = wdata_i[IDX_W-1:0];
  assign idx_ok_o  = (wdata_i < DATA_W'(NUM_SRC));

  always_comb begin
    unique case (rsel)
      RG_IDENT:  rdata_d = ID_CODE;
      RG_COUNT:  rdata_d = DATA_W'(cnt_i);
      RG_LOWEST: rdata_d = low_vld_i ? DATA_W'(low_idx_i) : '1;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end

  a_r12_read_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] ID_CODE = 32'hC1C0_0040
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic               off_all, off_one, on_one, idx_ok, low_vld;
  logic [IDX_W-1:0]   idx, low_idx;
  logic [NUM_SRC-1:0] pend, rise, fall;
  logic [CNT_W-1:0]   n_rise, n_fall, cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cic_regif #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .ID_CODE(ID_CODE)
  ) u_regif (
    .clk(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt_q),
    .low_idx_i(low_idx), .low_vld_i(low_vld),
    .off_all_o(off_all), .off_one_o(off_one), .on_one_o(on_one),
    .idx_o(idx), .idx_ok_o(idx_ok), .rdata_o(rdata_o)
  );

  cic_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_ni(rst_ni), .src_i(src_i),
    .off_all_i(off_all), .off_one_i(off_one), .on_one_i(on_one),
    .idx_i(idx), .idx_ok_i(idx_ok),
    .pend_o(pend), .rise_o(rise), .fall_o(fall)
  );

  cic_popcount #(.W(NUM_SRC), .OUT_W(CNT_W)) u_pc_rise (.vec_i(rise), .ones_o(n_rise));
  cic_popcount #(.W(NUM_SRC), .OUT_W(CNT_W)) u_pc_fall (.vec_i(fall), .ones_o(n_fall));

  cic_prio_enc #(.W(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_ni(rst_ni), .req_i(pend), .idx_o(low_idx), .vld_o(low_vld)
  );

  always_comb begin
    if (off_all) cnt_d = '0;
    else         cnt_d = cnt_q + n_rise - n_fall;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign irq_o = (cnt_q != '0);

  // R3, R9, R10: the running count never drifts from the pending set
  a_r3_count_tracks: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q == CNT_W'($countones(pend)));
  a_r3_irq_matches: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o == (|pend));
  a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_ni)
    off_all |=> (cnt_q == '0));
  a_r9_step_bounded: assert property (@(posedge clk) disable iff (!rst_ni)
    (!off_all && !on_one && !off_one && ($countones(rise) + $countones(fall) <= 1))
      |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
           || (cnt_q == $past(cnt_q) - 1'b1)));
endmodule

// File: tb/cnt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cnt_irq_ctrl_bench;
  localparam int N = 64;
  localparam logic [31:0] ID = 32'hC1C0_0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  logic [N-1:0]  lvl_m = '0, en_m = '0;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  cnt_irq_ctrl #(.NUM_SRC(N)) u_cnt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int exp_count();
    return $countones(lvl_m & en_m);
  endfunction

  function automatic logic [31:0] exp_lowest();
    for (int i = 0; i < N; i++) if (lvl_m[i] && en_m[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int r, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 12'(r << 2);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // one clock: new input levels and an optional write applied on the same edge
  task automatic step(input logic [N-1:0] lv, input bit w, input int r, input logic [31:0] d);
    @(negedge clk);
    src = lv; wr_en = w; addr = 12'(r << 2); wdata = d;
    @(posedge clk);
    lvl_m = lv;
    if (w) begin
      if (r == 3) en_m = '0;
      else if (r == 4 && d < N) en_m[d] = 1'b0;
      else if (r == 5 && d < N) en_m[d] = 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    check({tag, " irq (R3)"}, 32'(irq), 32'(exp_count() > 0));
    rd(1, v); check({tag, " count (R3)"}, v, 32'(exp_count()));
    rd(2, v); check({tag, " lowest (R4)"}, v, exp_lowest());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    logic [N-1:0] lv;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check("R1 irq after reset", 32'(irq), 32'd0);
    rd(1, v); check("R1 count after reset", v, 32'd0);
    rd(2, v); check("R4 lowest when none", v, 32'hFFFF_FFFF);

    // R2 map
    rd(0, v); check("R2 ident", v, ID);
    rd(3, v); check("R2 reg3 reads zero", v, 32'd0);
    rd(5, v); check("R2 reg5 reads zero", v, 32'd0);
    rd(6, v); check("R2 reg6 reads zero", v, 32'd0);
    rd(1023, v); check("R2 top reg reads zero", v, 32'd0);

    // R9 disabled inputs do nothing
    lv = '0; lv[5] = 1'b1; lv[9] = 1'b1;
    step(lv, 0, 0, 0); check_state("R9 disabled high");

    // R6 enable
    step(lv, 1, 5, 9);  check_state("R6 enable 9");
    step(lv, 1, 5, 5);  check_state("R6 enable 5");
    step(lv, 1, 5, 5);  check_state("R6 re-enable 5");
    step(lv, 1, 5, 40); check_state("R6 enable low 40");

    // R9 enabled input edges
    lv[40] = 1'b1; step(lv, 0, 0, 0); check_state("R9 rise 40");
    lv[5]  = 1'b0; step(lv, 0, 0, 0); check_state("R9 fall 5");

    // R7 disable
    step(lv, 1, 4, 40); check_state("R7 disable pending 40");
    step(lv, 1, 4, 40); check_state("R7 disable again 40");
    step(lv, 1, 4, 3);  check_state("R7 disable never-enabled 3");
    step(lv, 1, 4, 5);  check_state("R7 disable enabled idle 5");

    // R8 out of range aliasing live sources
    lv[0] = 1'b1; step(lv, 0, 0, 0);
    step(lv, 1, 5, 64);  check_state("R8 enable 64");
    step(lv, 1, 5, 32'hFFFF_FFC0); check_state("R8 enable huge");
    step(lv, 1, 4, 73);  check_state("R8 disable 73");

    // R11 writes to read-only / undefined
    step(lv, 1, 1, 0);   check_state("R11 write count reg");
    step(lv, 1, 2, 0);   check_state("R11 write lowest reg");
    step(lv, 1, 0, 0);   check_state("R11 write ident reg");
    step(lv, 1, 9, 0);   check_state("R11 write undefined reg");

    // R10 simultaneous write and input edge
    lv[63] = 1'b1; step(lv, 1, 5, 63); check_state("R10 enable with rise");
    lv[9]  = 1'b0; step(lv, 1, 4, 9);  check_state("R10 disable with fall");
    lv[63] = 1'b0; step(lv, 1, 5, 0);  check_state("R10 fall while other enable");

    // R5 disable all
    step(lv, 1, 5, 9); lv[9] = 1'b1;
    step(lv, 1, 3, 32'hDEAD_BEEF); check_state("R5 disable all");
    lv = '1; step(lv, 0, 0, 0); check_state("R5 inputs after disable all");

    // R12 read data holds without a read strobe
    step(lv, 1, 5, 7);
    rd(1, held);
    step(lv, 1, 5, 8);
    step(lv, 0, 0, 0);
    check("R12 rdata holds", rdata, held);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      lv = lvl_m;
      for (int k = 0; k < 3; k++) begin
        int b = $urandom_range(N - 1);
        if ($urandom_range(1) == 1) lv[b] = ~lv[b];
      end
      op = $urandom_range(19);
      d = 32'($urandom_range(N + 7));
      if (op < 8)       step(lv, 1, 5, d);
      else if (op < 15) step(lv, 1, 4, d);
      else if (op == 15) step(lv, 1, 3, d);
      else if (op == 16) step(lv, 1, $urandom_range(2), d);
      else              step(lv, 0, 0, 0);
      check_state("R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule